// File: doc/BRIEF.md
# Multi-Mode Serial Bit-Clock Generator

This block produces the timing enables for one channel of a serial port. An 8-bit divisor register sets the bit rate. Software can read the divisor at any time and loads it through a one-cycle write strobe. A 2-bit clock-select input picks a prescale of the operating clock by 1, 4, 16 or 64. A 2-bit mode input picks asynchronous, clocked synchronous or smart-card timing. In smart-card mode, a 2-bit bit-length input sets how many base clocks make up one bit.

The block has two outputs, both single-cycle enables. The base-clock enable fires once every 2·4^n·(N+1) input clocks. The bit-period enable fires once every L base ticks, where L depends on the mode. The divisor should be written only during setup. Writing it, or changing any timing input, restarts the whole divider chain from zero so that the next bit period follows the new setting.

Top module: `baud_gen_top`

## Requirements
- R1: After reset, rd_data reads 0xFF and both tick outputs are low.
- R2: A cycle with wr_en high loads wr_data into the divisor; rd_data shows the new value from the next cycle on and stays unchanged in cycles without wr_en.
- R3: The clock-select code cks gives n = 0, 1, 2 or 3 for codes 00, 01, 10, 11, and base_tick fires every 2·4^n·(N+1) clock cycles.
- R4: With mode code 00 (asynchronous), bit_tick fires once per 16 base ticks, i.e. every 32·4^n·(N+1) cycles; mode code 11 behaves the same way.
- R5: With mode code 01 (clocked synchronous), bit_tick fires once per 2 base ticks, i.e. every 4·4^n·(N+1) cycles.
- R6: With mode code 10 (smart card), bit_tick fires once per S base ticks, where bcp codes 00, 01, 10, 11 select S = 32, 64, 372, 256, i.e. every S·2·4^n·(N+1) cycles.
- R7: bit_tick is only ever high in a cycle where base_tick is also high, and the number of base ticks in each bit equals the mode's bit length.
- R8: A divisor write, or a change of cks, bcp or mode, clears all counters. The first bit_tick after it is high exactly one full bit period (for the new setting) after the clock edge that captures the change, and no base_tick occurs in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Divisor write strobe |
| wr_data | input | 8 | Divisor value to write |
| rd_data | output | 8 | Current divisor value |
| cks | input | 2 | Prescale exponent select |
| bcp | input | 2 | Smart-card bit length select |
| mode | input | 2 | Timing mode: 00 async, 01 sync, 10 smart card, 11 async |
| base_tick | output | 1 | Base-clock enable pulse |
| bit_tick | output | 1 | Bit-period enable pulse |

## Verification
The checker enforces several properties on every cycle: bit ticks coincide with base ticks, every bit contains exactly the configured number of base ticks, the divisor register loads and holds correctly, and the enables stay quiet right after a restart. The absolute spacing in clock cycles cannot be covered by those properties. That spacing depends on the prescale and divisor arithmetic, so only the bench's sweeps over modes, clock selects, bit lengths and divisor values can show it. The same holds for the exact latency from a write or configuration change to the first bit tick.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int DIV_W = 8;
  localparam int SEL_W = 2;
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);
  localparam int BIT_W = 9;

  typedef enum logic [1:0] {
    MD_ASYNC = 2'b00,
    MD_SYNC  = 2'b01,
    MD_CARD  = 2'b10,
    MD_ALT   = 2'b11
  } mode_e;

  // last prescaler count: 4^n - 1
  function automatic logic [PRE_W-1:0] pre_last(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] full;
    full = ({{PRE_W{1'b0}}, 1'b1} << (2 * sel));
    return PRE_W'(full - 1'b1);
  endfunction

  // last base-tick index within one bit
  function automatic logic [BIT_W-1:0] bit_last(input logic [1:0] md,
                                                input logic [1:0] len_sel);
    logic [BIT_W-1:0] r;
    case (mode_e'(md))
      MD_SYNC: r = BIT_W'(1);
      MD_CARD: begin
        case (len_sel)
          2'b00:   r = BIT_W'(31);
          2'b01:   r = BIT_W'(63);
          2'b10:   r = BIT_W'(371);
          default: r = BIT_W'(255);
        endcase
      end
      default: r = BIT_W'(15);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W = baud_pkg::SEL_W,
  parameter int PRE_W = baud_pkg::PRE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] last;

  assign last = baud_pkg::pre_last(sel);
  assign tick = (cnt == last) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (cnt == last)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W = baud_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             half;
  logic             wrap;

  assign wrap = step && (cnt == divisor);
  assign tick = wrap && half && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      half <= !half;
    end else if (step) begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/baud_bitcount.sv
module baud_bitcount #(
  parameter int BIT_W = baud_pkg::BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [BIT_W-1:0] last,
  output logic [BIT_W-1:0] count,
  output logic             tick
);
  assign tick = step && (count == last) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (tick)  count <= '0;
    else if (step)  count <= count + 1'b1;
  end
endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top #(
  parameter int DIV_W = baud_pkg::DIV_W,
  parameter int SEL_W = baud_pkg::SEL_W,
  parameter int PRE_W = baud_pkg::PRE_W,
  parameter int BIT_W = baud_pkg::BIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  output logic [DIV_W-1:0] rd_data,
  input  logic [SEL_W-1:0] cks,
  input  logic [1:0]       bcp,
  input  logic [1:0]       mode,
  output logic             base_tick,
  output logic             bit_tick
);
  localparam int CFG_W = SEL_W + 4;

  logic [DIV_W-1:0] divisor;
  logic [CFG_W-1:0] cfg_now, cfg_q;
  logic             restart;
  logic             pre_tick;
  logic [BIT_W-1:0] bit_len_last;
  logic [BIT_W-1:0] bit_cnt;

  assign cfg_now      = {cks, bcp, mode};
  assign restart      = wr_en || (cfg_now != cfg_q);
  assign bit_len_last = baud_pkg::bit_last(mode, bcp);
  assign rd_data      = divisor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divisor <= '1;
      cfg_q   <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (wr_en) divisor <= wr_data;
    end
  end

  baud_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(restart), .sel(cks), .tick(pre_tick)
  );

  baud_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(restart), .step(pre_tick),
    .divisor(divisor), .tick(base_tick)
  );

  baud_bitcount #(.BIT_W(BIT_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .clr(restart), .step(base_tick),
    .last(bit_len_last), .count(bit_cnt), .tick(bit_tick)
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int DIV_W = baud_pkg::DIV_W,
  parameter int BIT_W = baud_pkg::BIT_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_data,
  input logic [DIV_W-1:0] rd_data,
  input logic             base_tick,
  input logic             bit_tick,
  input logic             restart,
  input logic [BIT_W-1:0] bit_len_last
);
  logic [BIT_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen <= '0;
    else if (restart || bit_tick) seen <= '0;
    else if (base_tick)           seen <= seen + 1'b1;
  end

  a_r1_reset_read: assert property (@(posedge clk)
    $rose(rst_n) |-> rd_data == {DIV_W{1'b1}});

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  a_r7_bit_on_base: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick);

  a_r7_bit_len: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> seen == bit_len_last);

  a_r8_quiet_after_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !base_tick && !bit_tick);
endmodule

bind baud_gen_top baud_gen_chk #(.DIV_W(DIV_W), .BIT_W(BIT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .base_tick(base_tick), .bit_tick(bit_tick),
  .restart(restart), .bit_len_last(bit_len_last)
);

// File: tb/tb_baud_gen_top.sv
module tb_baud_gen_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] cks = '0, bcp = '0, mode = '0;
  logic       base_tick, bit_tick;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_gen_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cks(cks), .bcp(bcp), .mode(mode),
    .base_tick(base_tick), .bit_tick(bit_tick)
  );

  function automatic int len_of(input int md, input int b);
    int s;
    if (md == 1) return 2;
    if (md == 2) begin
      case (b)
        0: s = 32;
        1: s = 64;
        2: s = 372;
        default: s = 256;
      endcase
      return s;
    end
    return 16;
  endfunction

  function automatic int bit_period(input int md, input int c, input int b, input int n);
    return len_of(md, b) * 2 * (4 ** c) * (n + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bit(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!bit_tick);
  endtask

  task automatic wait_base(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!base_tick);
  endtask

  // set configuration and divisor together, then measure two bit gaps
  task automatic run_case(input string req, input int md, input int c,
                          input int b, input int n);
    int g;
    int exp;
    exp = bit_period(md, c, b, n);
    @(negedge clk);
    mode = 2'(md); cks = 2'(c); bcp = 2'(b);
    wr_en = 1'b1; wr_data = 8'(n);
    @(negedge clk);
    wr_en = 1'b0;
    wait_bit(g);
    check({req, " first gap"}, g + 1, exp);
    wait_bit(g);
    check({req, " steady gap"}, g, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset rd_data", int'(rd_data), 255);
    check("R1 reset base_tick", int'(base_tick), 0);
    check("R1 reset bit_tick", int'(bit_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write and readback
    wr_en = 1'b1; wr_data = 8'h5A;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h33;
    check("R2 readback", int'(rd_data), 'h5A);
    repeat (4) @(negedge clk);
    check("R2 hold", int'(rd_data), 'h5A);

    // R4: asynchronous sweep
    for (int n = 0; n < 4; n++) run_case("R4 async", 0, 0, 0, n);
    run_case("R4 async n1", 0, 1, 0, 2);
    run_case("R4 code11", 3, 0, 0, 1);

    // R5: synchronous with every clock select
    for (int c = 0; c < 4; c++) run_case("R5 sync", 1, c, 0, 1);
    run_case("R5 sync N=5", 1, 0, 0, 5);

    // R6: smart-card bit lengths
    for (int b = 0; b < 4; b++) run_case("R6 card", 2, 0, b, 0);
    run_case("R6 card 372 n1", 2, 1, 2, 1);

    // R3 / R7: base tick spacing, measured from a bit tick
    for (int c = 0; c < 4; c++) begin
      run_case("R3 setup", 1, c, 0, 2);
      wait_base(g);
      check("R3 base gap", g, 2 * (4 ** c) * 3);
      check("R7 base ticks per bit", int'(base_tick), 1);
    end

    // R8: mid-period divisor rewrite restarts the chain
    run_case("R8 setup", 0, 0, 0, 3);
    repeat (37) @(negedge clk);
    wr_en = 1'b1; wr_data = 8'd3;
    @(negedge clk);
    wr_en = 1'b0;
    check("R8 quiet after write", int'(base_tick), 0);
    wait_bit(g);
    check("R8 restart on write", g + 1, bit_period(0, 0, 0, 3));

    // R8: mode change mid-period restarts with the new period
    repeat (11) @(negedge clk);
    mode = 2'b01;
    @(negedge clk);
    check("R8 quiet after mode change", int'(base_tick), 0);
    wait_bit(g);
    check("R8 restart on mode", g + 1, bit_period(1, 0, 0, 3));

    // R8: bcp change in card mode
    mode = 2'b10; bcp = 2'b00;
    @(negedge clk);
    wait_bit(g);
    repeat (5) @(negedge clk);
    bcp = 2'b01;
    @(negedge clk);
    wait_bit(g);
    check("R8 restart on bcp", g + 1, bit_period(2, 0, 1, 3));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule